// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets a host load a bank of 8-bit configuration registers over three wires: an active-low enable, a serial clock and a serial data line. No read path exists. While the enable is low, each falling edge of the serial clock shifts one data bit in. Each group of sixteen bits forms one word: an 8-bit register address, sent most significant bit first, then 8 data bits, also most significant bit first. Each complete word performs one register write. The host may send several words back to back within one enable-low period. A word that is still incomplete when the enable rises is dropped.

All four external inputs (enable, serial clock, serial data and the hardware reset pin) are brought into the system clock domain through synchroniser chains. Falling edges of the serial clock are detected in that domain. For this reason the system clock must run at least four times faster than the serial clock. Apart from that limit, the serial clock may run as slowly as needed and with any duty cycle. The data line only needs to be stable for a few system cycles around each falling edge.

Two mechanisms restore every register to its default value: the hardware reset pin, and a software reset triggered by writing a 1 to bit 1 of register 0. The software reset bit clears itself. The register contents are presented as one flat registered vector. A one-cycle write strobe, together with the address and data of the write, marks each committed word.

Top module: `serial_cfg_port`

## Requirements
- R1: After the synchronous reset `rst`, register i holds its default (16*i+4) mod 256, and `wr_strobe` is low.
- R2: Serial clock falling edges that occur while `cfg_sen_n` is high shift nothing in, produce no strobe and change no register.
- R3: A word is committed on the 16th falling edge of `cfg_sclk` while `cfg_sen_n` stays low. The first 8 bits shifted in form the address and the last 8 form the data, each most significant bit first. `wr_addr` and `wr_data` carry those two fields.
- R4: Several consecutive 16-bit words within one enable-low period each commit their own write, in the order they were sent.
- R5: Bits left over beyond a whole multiple of 16 when `cfg_sen_n` rises cause no write. The next enable-low period starts a fresh word.
- R6: A word whose address is NUM_REGS or higher changes no register and raises no strobe.
- R7: A write to address 0 with data bit 1 set restores every register to its default. Afterwards register 0 reads back with bit 1 at 0. Data bit 1 written to any other address is stored as plain data.
- R8: A high level on `cfg_rst_pin` restores every register to its default.
- R9: `wr_strobe` is high for exactly one cycle per committed in-range word. In that same cycle `reg_flat` already shows the new value. Registers do not change in any other case.
- R10: Writes complete correctly with strongly asymmetric serial clock duty cycles, provided each serial clock phase lasts at least two system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sen_n | input | 1 | Serial enable, active low, asynchronous |
| cfg_sclk | input | 1 | Serial clock, asynchronous; data is taken on its falling edge |
| cfg_sdata | input | 1 | Serial data, asynchronous |
| cfg_rst_pin | input | 1 | Hardware register reset, active high, asynchronous |
| reg_flat | output | NUM_REGS*DATA_W | Register contents; register i sits at bits [i*DATA_W +: DATA_W] |
| wr_strobe | output | 1 | One-cycle pulse per committed write |
| wr_addr | output | ADDR_W | Address of the committed write |
| wr_data | output | DATA_W | Data of the committed write |

## Verification
The bench builds the port with NUM_REGS set to 8 instead of 16. This makes addresses 8 and 0x20 fall outside the bank, so the out-of-range path and the 7/8 address boundary can be exercised with ordinary 8-bit words. SYNC_STAGES is raised to 3, which lengthens the input latency. The bench uses a serial clock phase of just two system cycles to show that edge detection still keeps up at that latency. ADDR_W and DATA_W keep their 8-bit defaults, so every stream is built from 16-bit words.

// File: rtl/scp_pkg.sv
package scp_pkg;

  // Default value of configuration register idx; the self-clearing bit of
  // register 0 is always forced to zero so a reset never re-triggers itself.
  function automatic logic [63:0] cfg_default(int idx, int clr_bit);
    logic [63:0] v;
    v = 64'(idx * 16 + 4);
    if (idx == 0) v[clr_bit] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int                 WIDTH   = 4,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   IDLE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= IDLE_VAL;
        else     chain_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= IDLE_VAL;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  sen_s,
  input  logic                                  sclk_s,
  input  logic                                  sdata_s,
  output logic                                  word_vld,
  output logic [ADDR_W+DATA_W-1:0]              word,
  output logic [$clog2(ADDR_W+DATA_W)-1:0]      bit_cnt
);

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_prev;
  logic              fall;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shreg_nxt;

  assign fall      = sclk_prev & ~sclk_s;
  assign shreg_nxt = {shreg[WORD_W-2:0], sdata_s};

  always_ff @(posedge clk) begin
    word_vld <= 1'b0;
    if (rst) begin
      sclk_prev <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      word      <= '0;
    end else begin
      sclk_prev <= sclk_s;
      if (sen_s) begin
        // enable released: any partial word is dropped
        bit_cnt <= '0;
      end else if (fall) begin
        shreg <= shreg_nxt;
        if (bit_cnt == LAST) begin
          bit_cnt  <= '0;
          word     <= shreg_nxt;
          word_vld <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/scp_regbank.sv
module scp_regbank #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int SRST_BIT = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pin_s,
  input  logic                         word_vld,
  input  logic [ADDR_W+DATA_W-1:0]     word,
  output logic [NUM_REGS*DATA_W-1:0]   reg_flat,
  output logic                         wr_strobe,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [DATA_W-1:0]            wr_data
);

  localparam int WORD_W = ADDR_W + DATA_W;

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;
  logic              in_range;
  logic              soft_rst;
  logic              restore;

  assign addr     = word[WORD_W-1 -: ADDR_W];
  assign data     = word[DATA_W-1:0];
  assign in_range = int'(addr) < NUM_REGS;
  assign soft_rst = (addr == '0) && data[SRST_BIT];
  assign restore  = rst | pin_s;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF = DATA_W'(scp_pkg::cfg_default(g, SRST_BIT));
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (restore) begin
        q <= DEF;
      end else if (word_vld && in_range) begin
        if (soft_rst)               q <= DEF;
        else if (int'(addr) == g)   q <= data;
      end
    end

    assign reg_flat[g*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= word_vld & in_range & ~pin_s;
      if (word_vld) begin
        wr_addr <= addr;
        wr_data <= data;
      end
    end
  end

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SRST_BIT    = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_sen_n,
  input  logic                       cfg_sclk,
  input  logic                       cfg_sdata,
  input  logic                       cfg_rst_pin,
  output logic [NUM_REGS*DATA_W-1:0] reg_flat,
  output logic                       wr_strobe,
  output logic [ADDR_W-1:0]          wr_addr,
  output logic [DATA_W-1:0]          wr_data
);

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);

  // bit order on the synchroniser: {pin, sdata, sclk, sen_n}
  logic [3:0]        sync_out;
  logic              sen_s;
  logic              sclk_s;
  logic              sdata_s;
  logic              pin_s;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;

  scp_sync #(
    .WIDTH   (4),
    .STAGES  (SYNC_STAGES),
    .IDLE_VAL(4'b0011)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({cfg_rst_pin, cfg_sdata, cfg_sclk, cfg_sen_n}),
    .dout(sync_out)
  );

  assign sen_s   = sync_out[0];
  assign sclk_s  = sync_out[1];
  assign sdata_s = sync_out[2];
  assign pin_s   = sync_out[3];

  scp_shifter #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sen_s   (sen_s),
    .sclk_s  (sclk_s),
    .sdata_s (sdata_s),
    .word_vld(word_vld),
    .word    (word),
    .bit_cnt (bit_cnt)
  );

  scp_regbank #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .SRST_BIT(SRST_BIT)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .pin_s    (pin_s),
    .word_vld (word_vld),
    .word     (word),
    .reg_flat (reg_flat),
    .wr_strobe(wr_strobe),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int SRST_BIT = 1,
  parameter int CNT_W    = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_REGS*DATA_W-1:0] reg_flat,
  input logic                       wr_strobe,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic                       sen_s,
  input logic                       pin_s,
  input logic                       word_vld,
  input logic [CNT_W-1:0]           bit_cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W + DATA_W - 1);

  logic [NUM_REGS*DATA_W-1:0] defaults;
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_def
    assign defaults[g*DATA_W +: DATA_W] = DATA_W'(scp_pkg::cfg_default(g, SRST_BIT));
  end

  // R1
  reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> reg_flat == defaults);

  // R2
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    sen_s |=> bit_cnt == '0);

  // R3
  word_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> (bit_cnt == '0 && $past(bit_cnt) == LAST));

  // R6
  strobe_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> int'(wr_addr) < NUM_REGS);

  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_strobe && wr_addr == '0 && wr_data[SRST_BIT]) |-> reg_flat == defaults);

  // R8
  pin_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pin_s) |-> reg_flat == defaults);

  // R9
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |=> !wr_strobe);

  // R9
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(word_vld) && !$past(pin_s)) |-> $stable(reg_flat));

endmodule

bind serial_cfg_port scp_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .SRST_BIT(SRST_BIT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_flat (reg_flat),
  .wr_strobe(wr_strobe),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .sen_s    (sen_s),
  .pin_s    (pin_s),
  .word_vld (word_vld),
  .bit_cnt  (bit_cnt)
);

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;

  localparam int NR = 8;
  localparam int DW = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sen_n = 1'b1;
  logic sclk = 1'b1;
  logic sdata = 1'b0;
  logic pin = 1'b0;
  logic [NR*DW-1:0] reg_flat;
  logic             wr_strobe;
  logic [AW-1:0]    wr_addr;
  logic [DW-1:0]    wr_data;

  always #5 clk = ~clk;

  serial_cfg_port #(.NUM_REGS(NR), .SYNC_STAGES(3)) uut (
    .clk(clk), .rst(rst), .cfg_sen_n(sen_n), .cfg_sclk(sclk),
    .cfg_sdata(sdata), .cfg_rst_pin(pin), .reg_flat(reg_flat),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0]  model [NR];
  logic [15:0] exp_q [$];
  logic [15:0] got_w;
  bit          idle_chk = 1'b0;
  string       cur_req = "R1";

  function automatic logic [7:0] exp_def(int i);
    return 8'((16 * i + 4) % 256);
  endfunction

  function automatic logic [NR*DW-1:0] model_flat();
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = model[i];
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NR; i++) model[i] = exp_def(i);
  endtask

  // expected effect of one complete word
  task automatic apply(logic [15:0] w);
    if (int'(w[15:8]) < NR) begin
      exp_q.push_back(w);
      if (w[15:8] == 8'h00 && w[1]) model_reset();
      else model[w[15:8]] = w[7:0];
    end
  endtask

  task automatic bit_out(bit b, int hi, int lo);
    sdata = b;
    repeat (hi) @(negedge clk);
    sclk = 1'b0;
    repeat (lo) @(negedge clk);
    sclk = 1'b1;
  endtask

  task automatic send(logic [63:0] bits, int nbits, int hi, int lo, bit enable);
    idle_chk = 1'b0;
    if (enable) sen_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) bit_out(bits[i], hi, lo);
    repeat (8) @(negedge clk);
    sen_n = 1'b1;
    repeat (14) @(negedge clk);
    idle_chk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && wr_strobe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", {48'b0, wr_addr, wr_data}, 64'b0);
      end else begin
        got_w = exp_q.pop_front();
        check({wr_addr, wr_data} == got_w, "R3", {48'b0, wr_addr, wr_data}, {48'b0, got_w});
        if (got_w[15:8] == 8'h00 && got_w[1])
          check(reg_flat == model_flat(), "R7", reg_flat, model_flat());
        else
          check(reg_flat[int'(got_w[15:8])*DW +: DW] == got_w[7:0], "R9",
                reg_flat[int'(got_w[15:8])*DW +: DW], got_w[7:0]);
      end
    end
    if (idle_chk) begin
      check(reg_flat == model_flat(), cur_req, reg_flat, model_flat());
      check(!wr_strobe, cur_req, wr_strobe, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    check(!wr_strobe, "R1", wr_strobe, 0);
    idle_chk = 1'b1;
    repeat (6) @(negedge clk);

    cur_req = "R3";
    apply(16'h03A5);
    send({48'b0, 16'h03A5}, 16, 4, 4, 1'b1);

    cur_req = "R4";
    apply(16'h0111); apply(16'h0522); apply(16'h0733);
    send({16'h0, 16'h0111, 16'h0522, 16'h0733}, 48, 3, 3, 1'b1);

    cur_req = "R5";
    apply(16'h02C3);
    send({43'b0, 16'h02C3, 5'b10110}, 21, 3, 3, 1'b1);
    apply(16'h0466);
    send({48'b0, 16'h0466}, 16, 3, 3, 1'b1);

    cur_req = "R2";
    send({48'b0, 16'h0199}, 16, 3, 3, 1'b0);

    cur_req = "R6";
    send({48'b0, 16'h2077}, 16, 3, 3, 1'b1);
    send({48'b0, 16'h0855}, 16, 3, 3, 1'b1);
    apply(16'h0744);
    send({48'b0, 16'h0744}, 16, 3, 3, 1'b1);

    cur_req = "R7";
    apply(16'h0102);
    send({48'b0, 16'h0102}, 16, 3, 3, 1'b1);
    check(reg_flat[DW +: DW] == 8'h02, "R7", reg_flat[DW +: DW], 8'h02);
    apply(16'h0002);
    send({48'b0, 16'h0002}, 16, 3, 3, 1'b1);
    check(reg_flat[DW-1:0] == 8'h04, "R7", reg_flat[DW-1:0], 8'h04);

    cur_req = "R10";
    apply(16'h06F0);
    send({48'b0, 16'h06F0}, 16, 2, 40, 1'b1);
    apply(16'h050F);
    send({48'b0, 16'h050F}, 16, 40, 2, 1'b1);

    cur_req = "R8";
    idle_chk = 1'b0;
    pin = 1'b1;
    repeat (5) @(negedge clk);
    pin = 1'b0;
    model_reset();
    repeat (10) @(negedge clk);
    idle_chk = 1'b1;
    repeat (6) @(negedge clk);
    check(reg_flat[6*DW +: DW] == exp_def(6), "R8", reg_flat[6*DW +: DW], exp_def(6));

    idle_chk = 1'b0;
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule